// File: doc/BRIEF.md
# Page-Latched Self-Timed Array Write Engine

This block sits behind a serial-memory command decoder and handles the write path into a 2048-byte nonvolatile array. When the decoder sees a write command it strobes the start address into the engine. Each data byte that follows is then stored in a page-sized holding latch. The latch keeps a per-byte valid flag. Bytes that run past the last location of the physical page wrap back to the page's first location, so a later byte overwrites an earlier one.

When chip select returns high, the decoder tells the engine whether that happened exactly on a byte boundary. Only an aligned rise after at least one complete data byte commits the frame. Any other rise throws the latched frame away. A committed frame starts a self-timed program cycle whose length is a parameterised clock count. It stands in for a multi-millisecond program time. The busy flag is high for the whole cycle. During the first page-size cycles of the busy window, the held bytes are copied to the array one per clock. On the final busy cycle the engine pulses a request to clear the external write-enable latch.

The write-enable state is an input. A write frame is only opened if that latch was already set when the frame began. While the program cycle runs, new commands and bytes are ignored.

Top module: `pgwr_engine`

## Requirements
- R1: After reset `wip`, `wel_clr` and `arr_we` are all 0.
- R2: A `cmd_start` sampled while `wel_in` is 0 opens no frame, and a later aligned `cs_rise` causes no busy period and no array write.
- R3: The page of the frame is `cmd_addr[ADDR_W-1:log2(PAGE_BYTES)]`. The first byte goes to the in-page offset `cmd_addr[log2(PAGE_BYTES)-1:0]`, and each following byte goes to the next offset. Every array write has address `{page, offset}`.
- R4: The offset after `PAGE_BYTES-1` is 0 within the same page. When several bytes land on one offset, the array receives the last of them.
- R5: Only offsets that received a byte in the current frame are written. Every other array location keeps its contents, and the number of `arr_we` pulses equals the number of distinct offsets hit.
- R6: A frame commits only on a `cs_rise` sampled with `cs_aligned` = 1 after at least one byte. A `cs_rise` with `cs_aligned` = 0, or one that follows no byte, abandons the frame with no busy period and no write.
- R7: `wip` rises on the clock after the committing `cs_rise` and stays high for exactly `WRITE_CYCLES` cycles.
- R8: Array writes happen only while `wip` is high and within its first `PAGE_BYTES` cycles. They come one per clock in ascending offset order.
- R9: `wel_clr` is high for exactly one cycle, the last cycle of `wip`. It never pulses for an abandoned frame.
- R10: `cmd_start`, `byte_vld` and `cs_rise` arriving while `wip` is high have no effect: no change to the busy length, no extra writes, no later busy period.
- R11: A `cs_rise` with no open frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Write command strobe; opens a frame |
| cmd_addr | input | ADDR_W | Start address, valid with `cmd_start` |
| byte_vld | input | 1 | One complete data byte received |
| byte_data | input | DATA_W | Data byte, valid with `byte_vld` |
| cs_rise | input | 1 | Chip select has returned high |
| cs_aligned | input | 1 | The `cs_rise` fell exactly on a byte boundary |
| wel_in | input | 1 | Current state of the write-enable latch |
| wip | output | 1 | Program cycle in progress |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | ADDR_W | Array write address |
| arr_wdata | output | DATA_W | Array write data |

## Verification
A corrupted valid mask shows up within a single program cycle. It either writes a stale byte into a location that should be unchanged, or it leaves a received byte out. Either case appears as a mismatch in the full-array comparison, and as a write count that differs from the number of distinct offsets. A wrong offset pointer produces a mismatch at the wrapped location as soon as the frame commits. A faulty commit decision or timer shows up on the next busy window: `wip` has the wrong length or appears when it should not, and the `wel_clr` count is off by one.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PROG = 2'd2
  } pgwr_state_e;

  // Offset that follows `slot` inside a page of `page_bytes` entries.
  function automatic logic [31:0] next_slot(logic [31:0] slot, logic [31:0] page_bytes);
    return (slot + 32'd1) & (page_bytes - 32'd1);
  endfunction

  // True while the program-cycle tick still points at a page slot.
  function automatic logic tick_in_page(logic [31:0] tick, logic [31:0] page_bytes);
    return tick < page_bytes;
  endfunction

endpackage

// File: rtl/pgwr_latch.sv
module pgwr_latch #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [OFF_W-1:0]      wr_off,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [OFF_W-1:0]      rd_off,
  output logic [DATA_W-1:0]     rd_data,
  output logic [PAGE_BYTES-1:0] vld_mask
);

  logic [PAGE_BYTES*DATA_W-1:0] slot_flat;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [DATA_W-1:0] byte_q;
    logic              vld_q;
    logic              hit;

    assign hit = wr_en && (wr_off == OFF_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q <= '0;
        vld_q  <= 1'b0;
      end else if (clr) begin
        vld_q  <= 1'b0;
      end else if (hit) begin
        byte_q <= wr_data;
        vld_q  <= 1'b1;
      end
    end

    assign slot_flat[g*DATA_W +: DATA_W] = byte_q;
    assign vld_mask[g]                   = vld_q;
  end

  assign rd_data = slot_flat[rd_off*DATA_W +: DATA_W];

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int WRITE_CYCLES = 1000,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  output logic             busy,
  output logic             last,
  output logic [CNT_W-1:0] tick
);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign last = busy_q && (cnt_q == CNT_W'(WRITE_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (last) busy_q <= 1'b0;
      else      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy = busy_q;
  assign tick = cnt_q;

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic wel_in,
  input  logic cs_rise,
  input  logic cs_aligned,
  input  logic any_valid,
  input  logic prog_last,
  output logic frame_open,
  output logic frame_commit,
  output logic frame_abort,
  output logic fill_active,
  output logic in_prog
);

  pgwr_state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    frame_open   = 1'b0;
    frame_commit = 1'b0;
    frame_abort  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_start && wel_in) begin
          frame_open = 1'b1;
          state_d    = ST_FILL;
        end
      end
      ST_FILL: begin
        if (cs_rise) begin
          if (cs_aligned && any_valid) begin
            frame_commit = 1'b1;
            state_d      = ST_PROG;
          end else begin
            frame_abort = 1'b1;
            state_d     = ST_IDLE;
          end
        end
      end
      ST_PROG: begin
        if (prog_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign fill_active = (state_q == ST_FILL);
  assign in_prog     = (state_q == ST_PROG);

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
  import pgwr_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wel_in,
  output logic              wip,
  output logic              wel_clr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  // Named internal events (observed by the bound checker).
  logic frame_open, frame_commit, frame_abort;
  logic fill_active, ctrl_prog, prog_last, byte_take, any_valid, in_drain;

  logic [OFF_W-1:0]      off_q, drain_idx;
  logic [PG_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] vld_mask;
  logic [DATA_W-1:0]     rd_data;
  logic [CNT_W-1:0]      tick;

  assign byte_take = byte_vld && fill_active;
  assign any_valid = |vld_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= '0;
      page_q <= '0;
    end else if (frame_open) begin
      page_q <= cmd_addr[ADDR_W-1:OFF_W];
      off_q  <= cmd_addr[OFF_W-1:0];
    end else if (byte_take) begin
      off_q  <= OFF_W'(next_slot(32'(off_q), 32'(PAGE_BYTES)));
    end
  end

  pgwr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .wel_in      (wel_in),
    .cs_rise     (cs_rise),
    .cs_aligned  (cs_aligned),
    .any_valid   (any_valid),
    .prog_last   (prog_last),
    .frame_open  (frame_open),
    .frame_commit(frame_commit),
    .frame_abort (frame_abort),
    .fill_active (fill_active),
    .in_prog     (ctrl_prog)
  );

  pgwr_latch #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (frame_open),
    .wr_en   (byte_take),
    .wr_off  (off_q),
    .wr_data (byte_data),
    .rd_off  (drain_idx),
    .rd_data (rd_data),
    .vld_mask(vld_mask)
  );

  pgwr_timer #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .load (frame_commit),
    .busy (wip),
    .last (prog_last),
    .tick (tick)
  );

  assign in_drain  = wip && tick_in_page(32'(tick), 32'(PAGE_BYTES));
  assign drain_idx = tick[OFF_W-1:0];
  assign arr_we    = in_drain && vld_mask[drain_idx];
  assign arr_addr  = {page_q, drain_idx};
  assign arr_wdata = rd_data;
  assign wel_clr   = prog_last;

endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_rise,
  input logic              cs_aligned,
  input logic              wip,
  input logic              wel_clr,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              frame_open,
  input logic              frame_abort,
  input logic              ctrl_prog
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic [CNT_W-1:0]  run_q;
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      seen_q <= 1'b0;
      last_q <= '0;
    end else begin
      run_q <= wip ? run_q + 1'b1 : '0;
      if (!wip) seen_q <= 1'b0;
      else if (arr_we) begin
        seen_q <= 1'b1;
        last_q <= arr_addr;
      end
    end
  end

  // R6
  wip_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(cs_rise && cs_aligned));

  // R6
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !wip);

  // R7
  wip_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wip && run_q != '0) |-> run_q == CNT_W'(WRITE_CYCLES));

  // R7
  wip_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wip |-> run_q < CNT_W'(WRITE_CYCLES));

  // R7
  state_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_prog == wip);

  // R8
  we_in_wip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (wip && run_q < CNT_W'(PAGE_BYTES)));

  // R8
  we_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && seen_q) |-> (arr_addr > last_q &&
                            arr_addr[ADDR_W-1:OFF_W] == last_q[ADDR_W-1:OFF_W]));

  // R9
  clr_in_wip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> wip);

  // R9
  clr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |=> !wip);

  // R9
  clr_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> $past(wel_clr));

  // R10
  open_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_open |-> !wip);

endmodule

bind pgwr_engine pgwr_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_BYTES  (PAGE_BYTES),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_rise    (cs_rise),
  .cs_aligned (cs_aligned),
  .wip        (wip),
  .wel_clr    (wel_clr),
  .arr_we     (arr_we),
  .arr_addr   (arr_addr),
  .frame_open (frame_open),
  .frame_abort(frame_abort),
  .ctrl_prog  (ctrl_prog)
);

// File: tb/sim_pgwr_engine.sv
`timescale 1ns/1ps
module sim_pgwr_engine;
  localparam int ADDR_W = 11;
  localparam int DATA_W = 8;
  localparam int PAGE   = 16;
  localparam int WC     = 40;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_start, byte_vld, cs_rise, cs_aligned, wel_in;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] byte_data;
  logic wip, wel_clr, arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_wdata;

  always #2.5 clk = ~clk;

  pgwr_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE), .WRITE_CYCLES(WC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .wel_in(wel_in), .wip(wip), .wel_clr(wel_clr),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int we_tot = 0, wip_tot = 0, clr_tot = 0;

  logic [7:0] mem     [DEPTH];
  logic [7:0] exp_mem [DEPTH];

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 7 + 3) ^ (i >> 5));
  endfunction

  function automatic int page_start(int addr);
    return (addr / PAGE) * PAGE;
  endfunction

  function automatic int step_off(int off);
    return (off == PAGE - 1) ? 0 : off + 1;
  endfunction

  // Array model and activity counters.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
    end else if (arr_we) begin
      mem[arr_addr] <= arr_wdata;
      we_tot <= we_tot + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && wip)     wip_tot <= wip_tot + 1;
    if (rst_n && wel_clr) clr_tot <= clr_tot + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cmp_mem(input string tag);
    int bad = -1;
    for (int i = 0; i < DEPTH; i++) begin
      if (mem[i] !== exp_mem[i]) begin bad = i; break; end
    end
    if (bad < 0) chk(1'b1, tag, 0, 0);
    else begin
      $display("  mismatch at address %0d", bad);
      chk(1'b0, tag, int'(mem[bad]), int'(exp_mem[bad]));
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < WC + 20; i++) begin
      if (!wip) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  // One write frame: start, nbytes data bytes, then a chip-select rise.
  task automatic run_frame(input int addr, input int nbytes, input bit wel,
                           input bit aligned, input bit disturb, input string tag);
    logic [7:0] stg [PAGE];
    bit [PAGE-1:0] hit = '0;
    int off;
    bit commit;
    int w0, c0, e0;
    @(negedge clk);
    cmd_start = 1'b1; cmd_addr = ADDR_W'(addr); wel_in = wel;
    @(negedge clk);
    cmd_start = 1'b0;
    off = addr % PAGE;
    for (int k = 0; k < nbytes; k++) begin
      byte_vld = 1'b1; byte_data = 8'($urandom);
      stg[off] = byte_data; hit[off] = 1'b1; off = step_off(off);
      @(negedge clk);
      byte_vld = 1'b0;
    end
    commit = wel && aligned && (nbytes > 0);
    w0 = wip_tot; c0 = clr_tot; e0 = we_tot;
    cs_rise = 1'b1; cs_aligned = aligned;
    @(negedge clk);
    cs_rise = 1'b0; cs_aligned = 1'b0;
    // R6 / R7: busy begins on the clock after a committing chip-select rise
    chk(wip == commit, {tag, " R6 wip start"}, int'(wip), int'(commit));
    if (disturb && commit) begin
      // R10: traffic during the program cycle
      cmd_start = 1'b1; wel_in = 1'b1; cmd_addr = ADDR_W'($urandom_range(DEPTH - 1));
      @(negedge clk);
      cmd_start = 1'b0; byte_vld = 1'b1; byte_data = 8'($urandom);
      @(negedge clk);
      byte_vld = 1'b0; cs_rise = 1'b1; cs_aligned = 1'b1;
      @(negedge clk);
      cs_rise = 1'b0; cs_aligned = 1'b0;
    end
    wait_idle();
    if (commit) begin
      for (int s = 0; s < PAGE; s++)
        if (hit[s]) exp_mem[page_start(addr) + s] = stg[s];
    end
    chk(wip_tot - w0 == (commit ? WC : 0), {tag, " R7 wip length"}, wip_tot - w0, commit ? WC : 0);
    chk(clr_tot - c0 == int'(commit), {tag, " R9 wel_clr pulses"}, clr_tot - c0, int'(commit));
    chk(we_tot - e0 == (commit ? $countones(hit) : 0), {tag, " R5 write count"},
        we_tot - e0, commit ? $countones(hit) : 0);
    cmp_mem({tag, " R3/R4/R5 array"});
    if (disturb && commit) begin
      w0 = wip_tot;
      repeat (4) @(negedge clk);
      chk(wip_tot == w0, {tag, " R10 no late busy"}, wip_tot - w0, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'h1F3A_5C07));
    rst_n = 1'b0; cmd_start = 1'b0; byte_vld = 1'b0; cs_rise = 1'b0;
    cs_aligned = 1'b0; wel_in = 1'b0; cmd_addr = '0; byte_data = '0;
    for (int i = 0; i < DEPTH; i++) exp_mem[i] = init_val(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wip == 1'b0, "R1 wip", int'(wip), 0);
    chk(wel_clr == 1'b0, "R1 wel_clr", int'(wel_clr), 0);
    chk(arr_we == 1'b0, "R1 arr_we", int'(arr_we), 0);

    // R11: chip-select rise with no open frame
    w0 = wip_tot;
    cs_rise = 1'b1; cs_aligned = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0; cs_aligned = 1'b0;
    repeat (3) @(negedge clk);
    chk(wip_tot == w0, "R11 idle cs_rise", wip_tot - w0, 0);
    cmp_mem("R11 array");

    run_frame(37, 1, 1'b1, 1'b1, 1'b0, "R3 single byte");
    run_frame(256, PAGE, 1'b1, 1'b1, 1'b0, "R3 full page");
    run_frame(PAGE * 9 + 13, 20, 1'b1, 1'b1, 1'b0, "R4 wrap overwrite");
    run_frame(DEPTH - 3, 5, 1'b1, 1'b1, 1'b0, "R4 last page wrap");
    run_frame(500, 6, 1'b1, 1'b0, 1'b0, "R6 misaligned");
    run_frame(600, 0, 1'b1, 1'b1, 1'b0, "R6 no data");
    run_frame(700, 4, 1'b0, 1'b1, 1'b0, "R2 latch clear");
    run_frame(800, 3, 1'b1, 1'b1, 1'b1, "R10 busy traffic");
    run_frame(900, 2 * PAGE + 3, 1'b1, 1'b1, 1'b0, "R4 double wrap");

    for (int t = 0; t < 30; t++) begin
      run_frame($urandom_range(DEPTH - 1), $urandom_range(2 * PAGE + 4, 0),
                $urandom_range(9, 0) != 0, $urandom_range(6, 0) != 0,
                $urandom_range(4, 0) == 0, "rand");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule